// File: doc/BRIEF.md
# Display control register decoder

This block sits on the control-word path of a display engine. Each accepted 32-bit control word carries an operation code in its top byte and a payload below it. The decoder keeps a packed 32-bit status word, the display start coordinates, the horizontal and vertical display ranges, and a readback word, and updates them according to the operation code. It also keeps eight drawing-environment shadow words that the command parser writes through a separate port, so that query operations can return masked copies of them.

Operations covered are full reset, command-path reset, blanking on/off, DMA direction, display start, horizontal range, vertical range, display mode and information queries. Most operations are filtered: a word identical to the last one stored for the same operation code is dropped. The command-path reset leaves status alone and only emits a one-cycle request pulse toward the command parser. All results appear on the outputs in the cycle after the word is presented.

Top module: `ctl_decoder`

## Requirements
- R1: After hardware reset, and in the cycle after an accepted word with operation code 0x00, status reads 0x14802000, readback reads 0, display start and both ranges read 0, and environment shadow word i holds (0xE0+i) shifted left by 24; a shadow write presented in the same cycle as code 0x00 is discarded.
- R2: Codes 0x01 and 0x00 each raise cmd_reset_req for exactly the following cycle; code 0x01 leaves status, readback, display start and ranges unchanged.
- R3: Code 0x03 makes status bit 23 equal to payload bit 0.
- R4: Code 0x04 copies payload bits [1:0] into status bits [30:29].
- R5: Code 0x05 loads start X from payload bits [9:0] and start Y from payload bits [18:10].
- R6: Code 0x06 loads horizontal first/last from bits [11:0]/[23:12]; code 0x07 loads vertical first/last from bits [9:0]/[19:10].
- R7: Code 0x08 writes payload bits [5:0] into status bits [22:17] and payload bit 6 into status bit 16, leaving all other status bits as they were.
- R8: Codes 0x10 to 0x1F select by bits [3:0]: 2, 3 or 4 load readback with shadow word of that index masked to its low 20 bits; 5 loads shadow word 5 masked to 22 bits; 7 loads the value 2; every other selector leaves readback unchanged.
- R9: A word with code 0x02, 0x03, 0x04, 0x06, 0x07 or 0x08 that equals the last word stored for that code is ignored; codes 0x00, 0x01 and 0x05 are never filtered, so a repeated 0x01 pulses again. Hardware and full reset store 1 as the last word for code 0x03 and 0 for the rest.
- R10: With env_we high, shadow word env_idx takes env_data at the clock edge; a query in the same cycle returns the old shadow value.
- R11: The operation code is bits [31:24]; codes 0x09 to 0x0F and 0x20 to 0xFF change no output, and nothing changes while ctl_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_valid | input | 1 | Control word present this cycle |
| ctl_word | input | 32 | Control word, code in [31:24] |
| env_we | input | 1 | Shadow register write enable |
| env_idx | input | 3 | Shadow register index |
| env_data | input | 32 | Shadow register write data |
| status_word | output | 32 | Packed status word |
| readback_word | output | 32 | Query result |
| start_x | output | 10 | Display start X |
| start_y | output | 9 | Display start Y |
| hrange_first | output | 12 | Horizontal range first |
| hrange_last | output | 12 | Horizontal range last |
| vrange_first | output | 10 | Vertical range first |
| vrange_last | output | 10 | Vertical range last |
| cmd_reset_req | output | 1 | One-cycle command-path reset request |

## Verification
The bench aims at the duplicate filter, where a design comparing only the payload, or filtering codes 0x01 and 0x05, would drop a second command-path reset pulse or a repeated start address. It drives every query selector, including the unsupported ones, since a design that cleared readback on an unknown selector or masked with the wrong width would return corrupted environment values. It collides a shadow write with a full reset and with a query of the same index, catching designs that let the write survive the preset or forward the new value early. The mode remap is hit with patterns that distinguish bit 6 from bits [5:0], exposing a straight copy into status bits [22:16].

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned NUM_ENV    = 8;
    localparam int unsigned NUM_STORED = 9;
    localparam int unsigned STORED_IW  = $clog2(NUM_STORED);
    localparam int unsigned SX_W       = 10;
    localparam int unsigned SY_W       = 9;
    localparam int unsigned HR_W       = 12;
    localparam int unsigned VR_W       = 10;
    localparam int unsigned MASK_NARROW = 20;
    localparam int unsigned MASK_WIDE   = 22;
    localparam logic [WORD_W-1:0] STATUS_INIT = 32'h1480_2000;
    localparam int unsigned BLANK_BIT  = 23;
    localparam int unsigned DMA_LO     = 29;
    localparam int unsigned MODE_LO    = 16;

    typedef enum logic [7:0] {
        OP_FULL_RST  = 8'h00,
        OP_CMD_RST   = 8'h01,
        OP_BLANK     = 8'h03,
        OP_DMA_DIR   = 8'h04,
        OP_START     = 8'h05,
        OP_HRANGE    = 8'h06,
        OP_VRANGE    = 8'h07,
        OP_MODE      = 8'h08
    } ctl_op_e;

    typedef struct packed {
        logic [NUM_STORED-1:0][WORD_W-1:0] stored;
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] readback;
        logic [SX_W-1:0]   sx;
        logic [SY_W-1:0]   sy;
        logic [HR_W-1:0]   h_first;
        logic [HR_W-1:0]   h_last;
        logic [VR_W-1:0]   v_first;
        logic [VR_W-1:0]   v_last;
        logic              cmd_rst;
    } dec_state_t;

    function automatic dec_state_t dec_init();
        dec_state_t s;
        s = '0;
        s.stored[3] = WORD_W'(1);
        s.status    = STATUS_INIT;
        return s;
    endfunction
endpackage

// File: rtl/env_shadow.sv
module env_shadow
    import ctl_dec_pkg::*;
#(
    parameter int unsigned N = NUM_ENV
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       we,
    input  logic [$clog2(N)-1:0]       idx,
    input  logic [WORD_W-1:0]          wdata,
    output logic [N-1:0][WORD_W-1:0]   regs
);
    logic [N-1:0][WORD_W-1:0] shadow_d, shadow_q;

    for (genvar i = 0; i < N; i++) begin : g_entry
        localparam logic [WORD_W-1:0] PRESET = WORD_W'((32'hE0 + i) << 24);
        always_comb begin
            shadow_d[i] = shadow_q[i];
            if (clear)
                shadow_d[i] = PRESET;
            else if (we && (idx == ($clog2(N))'(i)))
                shadow_d[i] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) shadow_q[i] <= WORD_W'((32'hE0 + i) << 24);
        end else begin
            shadow_q <= shadow_d;
        end
    end

    assign regs = shadow_q;

    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clear) |=> (regs[$past(idx)] == $past(wdata)));

    a_r1_preset_tags: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (regs[0][31:24] == 8'hE0 && regs[N-1][31:24] == 8'(8'hE0 + N - 1)));
endmodule

// File: rtl/query_sel.sv
module query_sel
    import ctl_dec_pkg::*;
(
    input  logic [3:0]                      sel,
    input  logic [NUM_ENV-1:0][WORD_W-1:0]  env,
    output logic                            hit,
    output logic [WORD_W-1:0]               value
);
    localparam logic [WORD_W-1:0] NARROW = WORD_W'((64'd1 << MASK_NARROW) - 1);
    localparam logic [WORD_W-1:0] WIDE   = WORD_W'((64'd1 << MASK_WIDE) - 1);

    always_comb begin
        hit   = 1'b1;
        value = '0;
        unique case (sel)
            4'd2, 4'd3, 4'd4: value = env[sel[2:0]] & NARROW;
            4'd5:             value = env[5] & WIDE;
            4'd7:             value = WORD_W'(2);
            default:          hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
    import ctl_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_valid,
    input  logic [31:0]        ctl_word,
    input  logic               env_we,
    input  logic [2:0]         env_idx,
    input  logic [31:0]        env_data,
    output logic [31:0]        status_word,
    output logic [31:0]        readback_word,
    output logic [9:0]         start_x,
    output logic [8:0]         start_y,
    output logic [11:0]        hrange_first,
    output logic [11:0]        hrange_last,
    output logic [9:0]         vrange_first,
    output logic [9:0]         vrange_last,
    output logic               cmd_reset_req
);
    dec_state_t st_d, st_q;
    logic [NUM_ENV-1:0][WORD_W-1:0] env_q;
    logic [7:0]           op;
    logic [STORED_IW-1:0] op_idx;
    logic                 op_stored, dup, act, full_clr, q_hit;
    logic [WORD_W-1:0]    q_val;

    assign op        = ctl_word[31:24];
    assign op_idx    = op[STORED_IW-1:0];
    assign op_stored = (op < 8'(NUM_STORED));
    assign dup       = op_stored && (op > 8'h01) && (op != 8'(OP_START))
                       && (st_q.stored[op_idx] == ctl_word);
    assign act       = ctl_valid && !dup;
    assign full_clr  = act && (op == 8'(OP_FULL_RST));

    env_shadow #(.N(NUM_ENV)) u_env (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (full_clr),
        .we    (env_we),
        .idx   (env_idx),
        .wdata (env_data),
        .regs  (env_q)
    );

    query_sel u_query (
        .sel   (ctl_word[3:0]),
        .env   (env_q),
        .hit   (q_hit),
        .value (q_val)
    );

    always_comb begin
        st_d = st_q;
        st_d.cmd_rst = 1'b0;
        if (act) begin
            if (op_stored) st_d.stored[op_idx] = ctl_word;
            case (op)
                8'(OP_FULL_RST): begin
                    st_d = dec_init();
                    st_d.cmd_rst = 1'b1;
                end
                8'(OP_CMD_RST): st_d.cmd_rst = 1'b1;
                8'(OP_BLANK):   st_d.status[BLANK_BIT] = ctl_word[0];
                8'(OP_DMA_DIR): st_d.status[DMA_LO+1:DMA_LO] = ctl_word[1:0];
                8'(OP_START): begin
                    st_d.sx = ctl_word[SX_W-1:0];
                    st_d.sy = ctl_word[SX_W+SY_W-1:SX_W];
                end
                8'(OP_HRANGE): begin
                    st_d.h_first = ctl_word[HR_W-1:0];
                    st_d.h_last  = ctl_word[2*HR_W-1:HR_W];
                end
                8'(OP_VRANGE): begin
                    st_d.v_first = ctl_word[VR_W-1:0];
                    st_d.v_last  = ctl_word[2*VR_W-1:VR_W];
                end
                8'(OP_MODE): begin
                    st_d.status[MODE_LO+6:MODE_LO+1] = ctl_word[5:0];
                    st_d.status[MODE_LO]             = ctl_word[6];
                end
                default: begin
                    if (op[7:4] == 4'h1 && q_hit) st_d.readback = q_val;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= dec_init();
        else        st_q <= st_d;
    end

    assign status_word   = st_q.status;
    assign readback_word = st_q.readback;
    assign start_x       = st_q.sx;
    assign start_y       = st_q.sy;
    assign hrange_first  = st_q.h_first;
    assign hrange_last   = st_q.h_last;
    assign vrange_first  = st_q.v_first;
    assign vrange_last   = st_q.v_last;
    assign cmd_reset_req = st_q.cmd_rst;

    a_r2_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset_req |-> $past(ctl_valid && ctl_word[31:25] == 7'd0));

    a_r2_cmd_rst_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_word[31:24] == 8'h01) |=> ($stable(status_word) && cmd_reset_req));

    a_r4_dma_field: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_word[31:24] == 8'h04)
        |=> (status_word[30:29] == $past(ctl_word[1:0])));

    a_r5_start_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_word[31:24] == 8'h05)
        |=> (start_x == $past(ctl_word[9:0]) && start_y == $past(ctl_word[18:10])));

    a_r8_unknown_query_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_word[31:28] == 4'h1 && !(ctl_word[3:0] inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd7}))
        |=> $stable(readback_word));

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_valid |=> ($stable(status_word) && $stable(readback_word) && !cmd_reset_req));
endmodule

// File: tb/sim_ctl_decoder.sv
module sim_ctl_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_valid = 1'b0;
    logic [31:0] ctl_word = '0;
    logic        env_we = 1'b0;
    logic [2:0]  env_idx = '0;
    logic [31:0] env_data = '0;
    logic [31:0] status_word, readback_word;
    logic [9:0]  start_x, vrange_first, vrange_last;
    logic [8:0]  start_y;
    logic [11:0] hrange_first, hrange_last;
    logic        cmd_reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ctl_decoder u0 (
        .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_word(ctl_word),
        .env_we(env_we), .env_idx(env_idx), .env_data(env_data),
        .status_word(status_word), .readback_word(readback_word),
        .start_x(start_x), .start_y(start_y),
        .hrange_first(hrange_first), .hrange_last(hrange_last),
        .vrange_first(vrange_first), .vrange_last(vrange_last),
        .cmd_reset_req(cmd_reset_req)
    );

    logic [31:0] m_stat, m_rb;
    logic [9:0]  m_sx, m_v1, m_v2;
    logic [8:0]  m_sy;
    logic [11:0] m_h1, m_h2;
    logic        m_pulse;
    logic [31:0] m_stored [9];
    logic [31:0] m_env [8];

    task automatic model_reset();
        m_stat = 32'h1480_2000; m_rb = '0;
        m_sx = '0; m_sy = '0; m_h1 = '0; m_h2 = '0; m_v1 = '0; m_v2 = '0;
        for (int i = 0; i < 9; i++) m_stored[i] = (i == 3) ? 32'd1 : 32'd0;
        for (int i = 0; i < 8; i++) m_env[i] = (32'hE0 + i) << 24;
    endtask

    function automatic bit query_known(input logic [3:0] s);
        return (s == 2 || s == 3 || s == 4 || s == 5 || s == 7);
    endfunction

    function automatic logic [31:0] query_value(input logic [3:0] s);
        if (s == 5) return m_env[5] & 32'h003F_FFFF;
        if (s == 7) return 32'd2;
        return m_env[s[2:0]] & 32'h000F_FFFF;
    endfunction

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'h00: return "R1";
            8'h01: return "R2";
            8'h03: return "R3";
            8'h04: return "R4";
            8'h05: return "R5";
            8'h06, 8'h07: return "R6";
            8'h08: return "R7";
            default: return (op[7:4] == 4'h1) ? "R8" : "R11";
        endcase
    endfunction

    task automatic model_step(input bit v, input logic [31:0] w, input bit we,
                              input logic [2:0] idx, input logic [31:0] wd);
        logic [7:0] op;
        bit dup, rst_now;
        op = w[31:24];
        m_pulse = 1'b0;
        rst_now = 1'b0;
        dup = (op > 1 && op != 5 && op < 9) && (m_stored[op[3:0]] == w);
        if (v && !dup) begin
            if (op < 9) m_stored[op[3:0]] = w;
            case (op)
                8'h00: begin model_reset(); m_pulse = 1'b1; rst_now = 1'b1; end
                8'h01: m_pulse = 1'b1;
                8'h03: m_stat[23] = w[0];
                8'h04: m_stat[30:29] = w[1:0];
                8'h05: begin m_sx = w[9:0]; m_sy = w[18:10]; end
                8'h06: begin m_h1 = w[11:0]; m_h2 = w[23:12]; end
                8'h07: begin m_v1 = w[9:0]; m_v2 = w[19:10]; end
                8'h08: begin m_stat[22:17] = w[5:0]; m_stat[16] = w[6]; end
                default: if (op[7:4] == 4'h1 && query_known(w[3:0])) m_rb = query_value(w[3:0]);
            endcase
        end
        if (we && !rst_now) m_env[idx] = wd;
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "status", status_word, m_stat);
        chk(tag, "readback", readback_word, m_rb);
        chk(tag, "start", {13'd0, start_y, start_x}, {13'd0, m_sy, m_sx});
        chk(tag, "hrange", {8'd0, hrange_last, hrange_first}, {8'd0, m_h2, m_h1});
        chk(tag, "vrange", {12'd0, vrange_last, vrange_first}, {12'd0, m_v2, m_v1});
        chk(tag, "pulse", {31'd0, cmd_reset_req}, {31'd0, m_pulse});
    endtask

    task automatic step(input bit v, input logic [31:0] w, input bit we,
                        input logic [2:0] idx, input logic [31:0] wd, input string tag);
        ctl_valid = v; ctl_word = w; env_we = we; env_idx = idx; env_data = wd;
        @(posedge clk);
        model_step(v, w, we, idx, wd);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic ctl(input logic [31:0] w, input string tag);
        step(1'b1, w, 1'b0, 3'd0, 32'd0, tag);
    endtask

    initial begin
        logic [31:0] w, last;
        logic [7:0] op;
        void'($urandom(32'd7781));
        model_reset();
        m_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        ctl(32'h0300_0001, "R3");
        ctl(32'h0300_0000, "R3");
        ctl(32'h0400_0002, "R4");
        ctl(32'h0800_0040, "R7");
        ctl(32'h0800_003F, "R7");
        ctl(32'h0507_FFFF, "R5");
        ctl(32'h0612_3ABC, "R6");
        ctl(32'h070F_FFFF, "R6");
        ctl(32'h0100_0000, "R2");
        ctl(32'h0100_0000, "R9");
        ctl(32'h0400_0001, "R4");
        ctl(32'h0400_0001, "R9");
        ctl(32'h0505_0505, "R9");
        ctl(32'h0505_0505, "R9");
        step(1'b1, 32'h1000_0003, 1'b1, 3'd3, 32'hFFFF_FFFF, "R10");
        ctl(32'h1000_0003, "R10");
        ctl(32'h10AB_0005, "R8");
        ctl(32'h1000_0007, "R8");
        ctl(32'h1F00_000F, "R8");
        ctl(32'h1000_0006, "R8");
        ctl(32'h0900_1234, "R11");
        ctl(32'hFF00_0001, "R11");
        step(1'b0, 32'h0400_0003, 1'b0, 3'd0, 32'd0, "R11");
        step(1'b1, 32'h0000_0000, 1'b1, 3'd4, 32'h1234_5678, "R1");
        ctl(32'h1000_0004, "R1");
        ctl(32'h0300_0001, "R9");
        ctl(32'h0000_0000, "R9");
        last = 32'h0400_0001;
        for (int n = 0; n < 4000; n++) begin
            case ($urandom_range(0, 9))
                0, 1: w = last;
                2, 3: w = {4'h1, 4'($urandom_range(0, 15)), 24'($urandom)};
                4:    w = {8'($urandom_range(0, 31)), 24'($urandom)};
                default: w = {8'($urandom_range(1, 8)), 16'd0, 1'b0, 7'($urandom)} | {8'd0, 24'($urandom_range(0, 1)) << 10};
            endcase
            if ($urandom_range(0, 40) == 0) w = 32'h0000_0000;
            op = w[31:24];
            step($urandom_range(0, 7) != 0, w, $urandom_range(0, 3) == 0,
                 3'($urandom_range(0, 7)), $urandom, tag_of(op));
            last = w;
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule